// File: doc/BRIEF.md
# Multi-Channel Grouped PWM Generator

This block drives a bank of pulse-width-modulated outputs. Each channel counts clock ticks through a programmable period and holds its output at the active level for a programmable number of leading ticks. A polarity bit decides whether the active level is high or low. Software writes period, duty and polarity into shadow registers. A running channel copies all three into its working set together, and only on the last tick of a period, so an output never produces a pulse that mixes old and new settings.

Start and stop are issued through a command register. A stop does not cut the output short. The channel finishes the period in progress and then rests at its inactive level. Channels whose bits are set in a group mask act as one unit: a start or stop aimed at any member applies to every member at the same clock edge, so their counters stay in phase. Every completed period sets a sticky per-channel flag. The enabled flags are combined into one interrupt line.

Each channel runs a three-state machine. IDLE holds the output inactive. A start moves the channel to RUN and loads the shadow set at that edge. In RUN, a stop moves the channel to DRAIN, or straight to IDLE if the stop arrives on the last tick. In DRAIN, reaching the last tick moves the channel to IDLE, and a start moves it back to RUN with the counter continuing.

Top module: `pwm_bank`

## Requirements
- R1: After reset every channel is stopped, every output is 0, `irq` is 0, the flags read 0, period and duty read 0, and polarity reads 1.
- R2: The register map uses these addresses. When the address MSB is 0, the address selects channel `addr[AW-2:2]`, and `addr[1:0]` picks period (0), duty (1) or polarity (2, bit 0). Period is the tick count minus one. When the address MSB is 1, `addr[1:0]` picks the group mask (0), the command (1, reads 0), the flags (2) or the interrupt enables (3). The default map places these global registers at 16 to 19. Every stored register reads back what was written.
- R3: A command write with bit i of `[NCH-1:0]` set starts an idle channel i at that clock edge. Its counter is 0 in the following cycle, and it loads the shadow set. Its period lasts period+1 cycles, and the output is active for the first duty cycles of each period.
- R4: With polarity 1 the active level is high. With polarity 0 the active level is low. A stopped channel rests at the inverse of the polarity it last loaded. A polarity written while stopped takes effect at the next start.
- R5: A duty of 0 keeps the output inactive for the whole period. A duty of period+1 or more keeps it active for the whole period.
- R6: Shadow writes made during a period do not change the running output. All three values take effect together in the first cycle of the next period.
- R7: A command write with bit NCH+i set stops channel i after the period in progress completes. The channel is then idle at its inactive level.
- R8: Starting any channel in the group mask starts every idle member at the same edge, and their counters run in phase.
- R9: Stopping any channel in the group mask stops every member at the same period end.
- R10: A channel whose group bit is clear is unaffected by commands aimed at other channels. Clearing a channel's bit removes it from the group.
- R11: A start aimed at a running channel does not restart its period. A stop aimed at an idle channel has no effect.
- R12: Flag bit i is set at the end of each period of channel i and stays set until software writes 1 to that bit. Writing 0 leaves the flag set.
- R13: `irq` is 1 exactly when some flag bit is set whose interrupt-enable bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address (AW = clog2(NCH)+3) |
| reg_wdata | input | CW | Write data (CW must be at least 2*NCH) |
| reg_rdata | output | CW | Read data for `reg_addr`, combinational |
| pwm_out | output | NCH | Channel outputs |
| irq | output | 1 | Combined masked end-of-period interrupt |

## Verification
The bench times stop commands against the phase of the counter. It computes the exact cycle of the period end at which the output should fall to its inactive level. A design that cuts the output at once, or that runs one period too many, shows a wrong level on that cycle. Shadow writes are placed inside a long period, and the bench checks every cycle on both sides of the boundary. A design that applies a field immediately, or applies only some fields, produces a short or mixed pulse there. Grouped channels are started and stopped through a single member while non-members are watched. A design that fails to expand the group, or that leaks the command into non-members, shows outputs out of phase or outputs that move when they should not. The remaining cases are duty extremes, a repeated start on a running channel, and write-zero-versus-write-one on the flags. These catch off-by-one compares, restarts that should be ignored, and flags that clear without a 1 being written.

// File: rtl/pwm_bank_pkg.sv
`timescale 1ns/1ps
package pwm_bank_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_RUN   = 2'd1,
        CH_DRAIN = 2'd2
    } ch_state_e;

    // channel register field select (addr[1:0])
    localparam int FLD_PERIOD = 0;
    localparam int FLD_DUTY   = 1;
    localparam int FLD_POL    = 2;

    // global register select (addr[1:0] with addr MSB set)
    localparam int GREG_GROUP = 0;
    localparam int GREG_CMD   = 1;
    localparam int GREG_FLAG  = 2;
    localparam int GREG_IEN   = 3;

endpackage

// File: rtl/pwm_bank_sync.sv
`timescale 1ns/1ps
// Expands start/stop requests over the synchronization group.
module pwm_bank_sync #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] start_req_i,
    input  logic [NCH-1:0] stop_req_i,
    input  logic [NCH-1:0] group_i,
    output logic [NCH-1:0] start_o,
    output logic [NCH-1:0] stop_o
);

    logic hit_start;
    logic hit_stop;

    always_comb begin
        hit_start = |(start_req_i & group_i);
        hit_stop  = |(stop_req_i & group_i);
        start_o   = hit_start ? (start_req_i | group_i) : start_req_i;
        stop_o    = hit_stop  ? (stop_req_i  | group_i) : stop_req_i;
    end

endmodule

// File: rtl/pwm_bank_regs.sv
`timescale 1ns/1ps
// Register file: per-channel shadows, group mask, command decode,
// sticky end-of-period flags and interrupt enables.
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int AW  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [AW-1:0]            addr_i,
    input  logic [CW-1:0]            wdata_i,
    output logic [CW-1:0]            rdata_o,
    input  logic [NCH-1:0]           eop_i,
    output logic [NCH-1:0][CW-1:0]   sh_period_o,
    output logic [NCH-1:0][CW-1:0]   sh_duty_o,
    output logic [NCH-1:0]           sh_pol_o,
    output logic [NCH-1:0]           group_o,
    output logic [NCH-1:0]           cmd_start_o,
    output logic [NCH-1:0]           cmd_stop_o,
    output logic                     irq_o
);

    localparam int CHW = AW - 3;

    logic            is_glob;
    logic [CHW-1:0]  ch_sel;
    logic [1:0]      fld;
    logic            g_we;
    logic [NCH-1:0]  grp_q;
    logic [NCH-1:0]  ien_q;
    logic [NCH-1:0]  flag_q;
    logic [NCH-1:0]  clr_mask;

    assign is_glob = addr_i[AW-1];
    assign ch_sel  = addr_i[AW-2:2];
    assign fld     = addr_i[1:0];
    assign g_we    = we_i && is_glob;

    // per-channel shadow registers
    for (genvar i = 0; i < NCH; i++) begin : g_shadow
        logic          sel;
        logic [CW-1:0] per_q;
        logic [CW-1:0] duty_q;
        logic          pol_q;

        assign sel = we_i && !is_glob && (ch_sel == CHW'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                per_q  <= '0;
                duty_q <= '0;
                pol_q  <= 1'b1;
            end else if (sel) begin
                if (fld == 2'(FLD_PERIOD)) per_q  <= wdata_i;
                if (fld == 2'(FLD_DUTY))   duty_q <= wdata_i;
                if (fld == 2'(FLD_POL))    pol_q  <= wdata_i[0];
            end
        end

        assign sh_period_o[i] = per_q;
        assign sh_duty_o[i]   = duty_q;
        assign sh_pol_o[i]    = pol_q;
    end

    // command pulses act on the edge that takes the write
    always_comb begin
        cmd_start_o = '0;
        cmd_stop_o  = '0;
        clr_mask    = '0;
        if (g_we && fld == 2'(GREG_CMD)) begin
            cmd_start_o = wdata_i[NCH-1:0];
            cmd_stop_o  = wdata_i[2*NCH-1:NCH];
        end
        if (g_we && fld == 2'(GREG_FLAG)) begin
            clr_mask = wdata_i[NCH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_q  <= '0;
            ien_q  <= '0;
            flag_q <= '0;
        end else begin
            if (g_we && fld == 2'(GREG_GROUP)) grp_q <= wdata_i[NCH-1:0];
            if (g_we && fld == 2'(GREG_IEN))   ien_q <= wdata_i[NCH-1:0];
            // a new period end wins over a simultaneous clear
            flag_q <= (flag_q & ~clr_mask) | eop_i;
        end
    end

    assign group_o = grp_q;
    assign irq_o   = |(flag_q & ien_q);

    always_comb begin
        rdata_o = '0;
        if (!is_glob) begin
            for (int i = 0; i < NCH; i++) begin
                if (ch_sel == CHW'(i)) begin
                    unique case (fld)
                        2'(FLD_PERIOD): rdata_o    = sh_period_o[i];
                        2'(FLD_DUTY):   rdata_o    = sh_duty_o[i];
                        2'(FLD_POL):    rdata_o[0] = sh_pol_o[i];
                        default:        rdata_o    = '0;
                    endcase
                end
            end
        end else begin
            unique case (fld)
                2'(GREG_GROUP): rdata_o[NCH-1:0] = grp_q;
                2'(GREG_FLAG):  rdata_o[NCH-1:0] = flag_q;
                2'(GREG_IEN):   rdata_o[NCH-1:0] = ien_q;
                default:        rdata_o          = '0;
            endcase
        end
    end

    // R12: a set flag survives every cycle in which its bit is not written with 1
    p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & $past(flag_q & ~clr_mask)) == $past(flag_q & ~clr_mask)));

endmodule

// File: rtl/pwm_bank_chan.sv
`timescale 1ns/1ps
// One PWM channel: counter, working configuration and run/drain/idle control.
module pwm_bank_chan
    import pwm_bank_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic [CW-1:0] sh_period_i,
    input  logic [CW-1:0] sh_duty_i,
    input  logic          sh_pol_i,
    output logic          out_o,
    output logic          eop_o
);

    ch_state_e     state_q;
    ch_state_e     state_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] per_q;
    logic [CW-1:0] duty_q;
    logic          pol_q;
    logic          at_end;
    logic          load;

    assign at_end = (cnt_q == per_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (start_i) state_d = CH_RUN;
            end
            CH_RUN: begin
                if (stop_i) state_d = at_end ? CH_IDLE : CH_DRAIN;
            end
            CH_DRAIN: begin
                if (start_i)     state_d = CH_RUN;
                else if (at_end) state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // working set reloads on a start from idle, or on a period end that keeps running
    assign load = (state_q == CH_IDLE) ? start_i : (at_end && (state_d != CH_IDLE));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // counter and working configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            per_q  <= '0;
            duty_q <= '0;
            pol_q  <= 1'b1;
        end else begin
            if (state_q == CH_IDLE || at_end) cnt_q <= '0;
            else                              cnt_q <= cnt_q + 1'b1;
            if (load) begin
                per_q  <= sh_period_i;
                duty_q <= sh_duty_i;
                pol_q  <= sh_pol_i;
            end
        end
    end

    // outputs
    always_comb begin
        eop_o = (state_q != CH_IDLE) && at_end;
        unique case (state_q)
            CH_IDLE:          out_o = ~pol_q;
            CH_RUN, CH_DRAIN: out_o = (cnt_q < duty_q) ? pol_q : ~pol_q;
            default:          out_o = ~pol_q;
        endcase
    end

    // R3: a running counter never passes the loaded period
    p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CH_IDLE) |-> (cnt_q <= per_q));

    // R6: inside a period the working set does not move
    p_cfg_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CH_IDLE && !at_end) |=>
            ($stable(per_q) && $stable(duty_q) && $stable(pol_q)));

    // R7: a draining channel goes idle right after its last tick
    p_drain_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_DRAIN && at_end && !start_i) |=> (state_q == CH_IDLE));

endmodule

// File: rtl/pwm_bank.sv
`timescale 1ns/1ps
// Multi-channel PWM bank with shadowed configuration and a synchronization group.
module pwm_bank #(
    parameter  int NCH = 4,
    parameter  int CW  = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int AW  = CHW + 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [AW-1:0]  reg_addr,
    input  logic [CW-1:0]  reg_wdata,
    output logic [CW-1:0]  reg_rdata,
    output logic [NCH-1:0] pwm_out,
    output logic           irq
);

    logic [NCH-1:0][CW-1:0] sh_period;
    logic [NCH-1:0][CW-1:0] sh_duty;
    logic [NCH-1:0]         sh_pol;
    logic [NCH-1:0]         grp;
    logic [NCH-1:0]         cmd_start;
    logic [NCH-1:0]         cmd_stop;
    logic [NCH-1:0]         start_vec;
    logic [NCH-1:0]         stop_vec;
    logic [NCH-1:0]         eop_vec;

    pwm_bank_regs #(.NCH(NCH), .CW(CW), .AW(AW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (reg_we),
        .addr_i      (reg_addr),
        .wdata_i     (reg_wdata),
        .rdata_o     (reg_rdata),
        .eop_i       (eop_vec),
        .sh_period_o (sh_period),
        .sh_duty_o   (sh_duty),
        .sh_pol_o    (sh_pol),
        .group_o     (grp),
        .cmd_start_o (cmd_start),
        .cmd_stop_o  (cmd_stop),
        .irq_o       (irq)
    );

    pwm_bank_sync #(.NCH(NCH)) u_sync (
        .start_req_i (cmd_start),
        .stop_req_i  (cmd_stop),
        .group_i     (grp),
        .start_o     (start_vec),
        .stop_o      (stop_vec)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        pwm_bank_chan #(.CW(CW)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .start_i     (start_vec[i]),
            .stop_i      (stop_vec[i]),
            .sh_period_i (sh_period[i]),
            .sh_duty_i   (sh_duty[i]),
            .sh_pol_i    (sh_pol[i]),
            .out_o       (pwm_out[i]),
            .eop_o       (eop_vec[i])
        );
    end

    // R8: a start touching the group reaches every member
    p_group_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(cmd_start & grp)) |-> ((start_vec & grp) == grp));

    // R9: a stop touching the group reaches every member
    p_group_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(cmd_stop & grp)) |-> ((stop_vec & grp) == grp));

    // R10: commands never reach a non-member that was not addressed
    p_no_leak_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((start_vec | stop_vec) & ~grp) == ((cmd_start | cmd_stop) & ~grp));

endmodule

// File: tb/pwm_bank_bench.sv
`timescale 1ns/1ps
module pwm_bank_bench;

    localparam int NCH = 4;
    localparam int CW  = 16;
    localparam int A_GRP  = 16;
    localparam int A_CMD  = 17;
    localparam int A_FLAG = 18;
    localparam int A_IEN  = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [4:0]    reg_addr = '0;
    logic [CW-1:0] reg_wdata = '0;
    logic [CW-1:0] reg_rdata;
    logic [NCH-1:0] pwm_out;
    logic          irq;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int   cyc;
        int   ch;
        logic val;
        int   req;
    } exp_t;

    exp_t sb[$];

    pwm_bank u_pwm_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out),
        .irq       (irq)
    );

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops expected output levels due in this cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].cyc == cyc) begin
                n_chk++;
                if (pwm_out[sb[i].ch] !== sb[i].val) begin
                    n_fail++;
                    $display("FAIL R%0d ch%0d cycle %0d: actual %b expected %b",
                             sb[i].req, sb[i].ch, cyc, pwm_out[sb[i].ch], sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    task automatic push(input int c, input int ch, input logic v, input int r);
        exp_t e;
        e.cyc = c; e.ch = ch; e.val = v; e.req = r;
        sb.push_back(e);
    endtask

    // expected waveform of a running channel started with counter 0 at cycle base
    task automatic exp_run(input int ch, input int base, input int from, input int to,
                           input int t, input int duty, input logic pol, input int r);
        for (int c = from; c <= to; c++) begin
            int k;
            k = (c - base) % t;
            push(c, ch, (k < duty) ? pol : ~pol, r);
        end
    endtask

    task automatic exp_lvl(input int ch, input int from, input int to,
                           input logic v, input int r);
        for (int c = from; c <= to; c++) push(c, ch, v, r);
    endtask

    // first idle cycle after a stop whose write edge yields cycle s
    function automatic int stop_idle(input int base, input int s, input int t);
        int c;
        if (((s - 1 - base) % t) == t - 1) return s;
        c = s;
        while (((c - base) % t) != t - 1) c++;
        return c + 1;
    endfunction

    // R7: the period in progress finishes, then the output rests inactive
    task automatic post_stop(input int ch, input int base, input int s, input int t,
                             input int duty, input logic pol, input int r,
                             output int idle);
        idle = stop_idle(base, s, t);
        exp_run(ch, base, s + 1, idle - 1, t, duty, pol, r);
        exp_lvl(ch, (idle > s) ? idle : s + 1, idle + 4, ~pol, r);
    endtask

    task automatic wr(input int a, input int d);
        reg_we    = 1'b1;
        reg_addr  = a[4:0];
        reg_wdata = d[CW-1:0];
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic chk(input string req, input int act, input int expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic rdchk(input int a, input int expv, input string req);
        reg_addr = a[4:0];
        #2;
        chk(req, int'(reg_rdata), expv);
        @(negedge clk);
    endtask

    task automatic wait_past(input int c);
        while (cyc <= c) @(negedge clk);
    endtask

    function automatic int ca(input int ch, input int f);
        return ch * 4 + f;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        int b;
        int s;
        int i0;
        int i1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 outputs", int'(pwm_out), 0);
        chk("R1 irq", int'(irq), 0);
        rdchk(A_FLAG, 0, "R1 flags");
        rdchk(ca(0, 2), 1, "R1 polarity");
        rdchk(ca(1, 0), 0, "R1 period");

        // R2: configuration and readback
        wr(ca(0, 0), 4); wr(ca(0, 1), 2); wr(ca(0, 2), 1);
        wr(ca(1, 0), 9); wr(ca(1, 1), 1); wr(ca(1, 2), 0);
        rdchk(ca(1, 0), 9, "R2 period");
        rdchk(ca(1, 1), 1, "R2 duty");
        rdchk(ca(1, 2), 0, "R2 polarity");
        wr(A_IEN, 3);
        rdchk(A_IEN, 3, "R2 irq enable");
        wr(A_IEN, 0);
        rdchk(A_CMD, 0, "R2 command reads 0");
        // R4: polarity written while stopped does not move the idle level yet
        chk("R4 idle before start", int'(pwm_out[1]), 0);

        // R3 / R4: start ch0 (active high) and ch1 (active low)
        wr(A_CMD, 'b0011);
        b = cyc;
        exp_run(0, b, b + 1, b + 15, 5, 2, 1'b1, 3);
        exp_run(1, b, b + 1, b + 15, 10, 1, 1'b0, 4);
        wait_past(b + 15);
        // R7: stop both mid-period
        wr(A_CMD, 'b0011 << NCH);
        s = cyc;
        post_stop(0, b, s, 5, 2, 1'b1, 7, i0);
        post_stop(1, b, s, 10, 1, 1'b0, 7, i1);
        wait_past(((i0 > i1) ? i0 : i1) + 4);

        // R6: shadow writes inside a long period apply together at its end
        wr(ca(2, 0), 19); wr(ca(2, 1), 5);
        wr(A_CMD, 'b0100);
        b = cyc;
        wr(ca(2, 1), 3);
        wr(ca(2, 0), 7);
        exp_run(2, b, b + 3, b + 19, 20, 5, 1'b1, 6);
        exp_run(2, b + 20, b + 20, b + 35, 8, 3, 1'b1, 6);
        // R11: a start to the running channel must not restart it
        while (cyc < b + 23) @(negedge clk);
        wr(A_CMD, 'b0100);
        wait_past(b + 35);
        wr(A_CMD, 'b0100 << NCH);
        s = cyc;
        post_stop(2, b + 20, s, 8, 3, 1'b1, 7, i0);
        wait_past(i0 + 4);
        // R11: a stop to an idle channel changes nothing
        wr(A_CMD, 'b0100 << NCH);
        s = cyc;
        exp_lvl(2, s + 1, s + 6, 1'b0, 11);
        wait_past(s + 6);

        // R5: duty extremes
        wr(ca(0, 0), 3); wr(ca(0, 1), 0);
        wr(ca(3, 0), 3); wr(ca(3, 1), 4); wr(ca(3, 2), 1);
        wr(A_CMD, 'b1001);
        b = cyc;
        exp_lvl(0, b + 1, b + 12, 1'b0, 5);
        exp_lvl(3, b + 1, b + 12, 1'b1, 5);
        wait_past(b + 12);
        wr(A_CMD, 'b1001 << NCH);
        s = cyc;
        post_stop(0, b, s, 4, 0, 1'b1, 5, i0);
        post_stop(3, b, s, 4, 4, 1'b1, 5, i1);
        wait_past(((i0 > i1) ? i0 : i1) + 4);

        // R8 / R9 / R10: group of ch1 and ch3
        wr(ca(1, 0), 4); wr(ca(1, 1), 2); wr(ca(1, 2), 1);
        wr(ca(3, 0), 4); wr(ca(3, 1), 4);
        wr(A_GRP, 'b1010);
        rdchk(A_GRP, 'b1010, "R2 group");
        wr(A_CMD, 'b0010);          // R8: start only ch1
        b = cyc;
        exp_run(1, b, b + 1, b + 12, 5, 2, 1'b1, 8);
        exp_run(3, b, b + 1, b + 12, 5, 4, 1'b1, 8);
        exp_lvl(0, b + 1, b + 12, 1'b0, 10);
        exp_lvl(2, b + 1, b + 12, 1'b0, 10);
        wait_past(b + 12);
        wr(A_CMD, 'b1000 << NCH);   // R9: stop only ch3
        s = cyc;
        post_stop(1, b, s, 5, 2, 1'b1, 9, i0);
        post_stop(3, b, s, 5, 4, 1'b1, 9, i1);
        wait_past(i0 + 4);

        // R10: ch3 removed from the group
        wr(A_GRP, 'b0010);
        wr(A_CMD, 'b0010);
        b = cyc;
        exp_run(1, b, b + 1, b + 10, 5, 2, 1'b1, 10);
        exp_lvl(3, b + 1, b + 10, 1'b0, 10);
        wait_past(b + 10);
        wr(A_CMD, 'b0010 << NCH);
        s = cyc;
        post_stop(1, b, s, 5, 2, 1'b1, 10, i0);
        wait_past(i0 + 4);

        // R12 / R13: sticky flags, write-one clear, masked interrupt
        rdchk(A_FLAG, 'hF, "R12 all flags set");
        chk("R13 irq masked", int'(irq), 0);
        wr(A_IEN, 'b0100);
        chk("R13 irq enabled", int'(irq), 1);
        wr(A_FLAG, 0);
        rdchk(A_FLAG, 'hF, "R12 write 0 keeps flags");
        wr(A_FLAG, 'b1011);
        rdchk(A_FLAG, 'b0100, "R12 partial clear");
        chk("R13 irq still set", int'(irq), 1);
        wr(A_FLAG, 'b0100);
        rdchk(A_FLAG, 0, "R12 cleared");
        chk("R13 irq dropped", int'(irq), 0);
        wr(A_IEN, 'b0001);
        wr(A_CMD, 'b0001);
        repeat (6) @(negedge clk);
        rdchk(A_FLAG, 'b0001, "R12 flag from running channel");
        chk("R13 irq from channel 0", int'(irq), 1);
        wr(A_CMD, 'b0001 << NCH);
        repeat (6) @(negedge clk);
        wr(A_FLAG, 'b0001);
        rdchk(A_FLAG, 0, "R12 cleared after stop");
        chk("R13 irq low after clear", int'(irq), 0);

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule